// File: doc/BRIEF.md
# Absolute-Difference Accumulating Response Analyzer

This block compresses the digitized response of an analog path under self-test into a single running total. On each sample it picks an operand and adds it into a two-half accumulator. The operand is one of three things. In magnitude mode it is the converted analog sample. In difference mode it is the exact absolute difference between the stimulus word and the converted sample. In a digital self-check mode it is the stimulus word itself, which checks the test logic without the analog path. Summing absolute differences makes noise, phase shift and ringing grow the total. Software later judges the total against an acceptance window rather than one exact value.

The test controller pulses `start` to clear the total at the beginning of a run. It holds `acc_en` high on the cycles whose samples count. After the run, the low and high halves are read as separate words. The low half carries into the high half in the same cycle. A total that would exceed the combined width sticks at all ones.

Top module: `ora_resp_analyzer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both `acc_hi` and `acc_lo` become zero.
- R2: A high `start` at a rising edge clears both halves to zero, even when `acc_en` is also high.
- R3: With `start` and `acc_en` both low, the accumulator keeps its value whatever the data and mode inputs do.
- R4: With `mode` = 2'b00 (magnitude), each enabled cycle adds `adc_data`, zero-extended.
- R5: With `mode` = 2'b01 (difference), each enabled cycle adds |`tpg_data` − `adc_data`|, taken as unsigned values and computed one bit wider, so the result is exact and never wraps. Equal inputs add zero.
- R6: With `mode` = 2'b10 (self-check), each enabled cycle adds `tpg_data`, zero-extended.
- R7: With `mode` = 2'b11 (reserved), enabled cycles add zero.
- R8: {`acc_hi`,`acc_lo`} acts as one unsigned sum of 2·HALF_W bits. A carry out of the low half increments the high half in the same cycle.
- R9: If an addition would exceed the all-ones value of the combined sum, both halves become all ones. They stay all ones under further additions until `start` or reset.
- R10: The outputs are registered. A sample presented at a rising edge shows in the outputs right after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Clear the accumulator for a new run |
| acc_en | input | 1 | Add this cycle's operand |
| mode | input | 2 | Operand select: 00 magnitude, 01 difference, 10 self-check, 11 none |
| tpg_data | input | TPG_W | Stimulus word sent to the converter |
| adc_data | input | ADC_W | Converted response sample |
| acc_hi | output | HALF_W | Upper half of the total |
| acc_lo | output | HALF_W | Lower half of the total |

## Verification
The assertions assume that HALF_W is at least the wider of the two data widths, so one operand can never carry more than once out of the low half. They also assume that `start` and `acc_en` are sampled only at clock edges. The stimulus uses 4-bit data and 6-bit halves, which meets the width rule. It changes every input only at the falling edge. The bench runs every operand pair in each mode, so the low half wraps many times. It then drives a long run of full-scale samples to reach saturation and hold there.

// File: rtl/ora_pkg.sv
// Package: shared operand-mode encoding for the response analyzer.
// Assumes the top port `mode` carries these two-bit values.
package ora_pkg;
    typedef enum logic [1:0] {
        MODE_MAG  = 2'b00,  // add converted sample
        MODE_DIFF = 2'b01,  // add |stimulus - sample|
        MODE_SELF = 2'b10,  // add stimulus word (digital self-check)
        MODE_NONE = 2'b11   // reserved: add zero
    } ora_mode_e;
endpackage

// File: rtl/ora_absdiff.sv
// Module: exact unsigned absolute difference of two words of possibly
// different widths. Both are widened to OP_W+1 bits before subtracting,
// so the sign bit is always valid and the magnitude fits in OP_W bits.
// Assumes OP_W >= A_W and OP_W >= B_W.
module ora_absdiff #(
    parameter int A_W  = 4,
    parameter int B_W  = 4,
    parameter int OP_W = (A_W > B_W) ? A_W : B_W
) (
    input  logic [A_W-1:0]  a_i,
    input  logic [B_W-1:0]  b_i,
    output logic [OP_W-1:0] mag_o
);
    localparam int EXT_W = OP_W + 1;

    logic [EXT_W-1:0] a_ext;
    logic [EXT_W-1:0] b_ext;
    logic [EXT_W-1:0] diff;
    logic [EXT_W-1:0] neg;

    // Purpose: widen, subtract and fold the negative case.
    always_comb begin
        a_ext = EXT_W'(a_i);
        b_ext = EXT_W'(b_i);
        diff  = a_ext - b_ext;
        neg   = b_ext - a_ext;
        mag_o = diff[EXT_W-1] ? neg[OP_W-1:0] : diff[OP_W-1:0];
    end
endmodule

// File: rtl/ora_operand_mux.sv
// Module: picks the per-sample operand from the mode select.
// Assumes OP_W is at least both data widths; narrower words are zero-extended.
module ora_operand_mux
    import ora_pkg::*;
#(
    parameter int TPG_W = 4,
    parameter int ADC_W = 4,
    parameter int OP_W  = (TPG_W > ADC_W) ? TPG_W : ADC_W
) (
    input  ora_mode_e         mode_i,
    input  logic [TPG_W-1:0]  tpg_i,
    input  logic [ADC_W-1:0]  adc_i,
    input  logic [OP_W-1:0]   absdiff_i,
    output logic [OP_W-1:0]   op_o
);
    // Purpose: route one of the candidate operands.
    always_comb begin
        unique case (mode_i)
            MODE_MAG:  op_o = OP_W'(adc_i);
            MODE_DIFF: op_o = absdiff_i;
            MODE_SELF: op_o = OP_W'(tpg_i);
            default:   op_o = '0;
        endcase
    end
endmodule

// File: rtl/ora_accum.sv
// Module: two-half accumulator. The low half adds the operand; its carry
// increments the high half in the same cycle; overflow of the high half
// forces both halves to all ones. Clear wins over enable.
// Assumes OP_W <= HALF_W so one operand carries at most once.
module ora_accum #(
    parameter int OP_W   = 4,
    parameter int HALF_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic [OP_W-1:0]   op_i,
    output logic [HALF_W-1:0] hi_o,
    output logic [HALF_W-1:0] lo_o
);
    localparam int SUM_W = HALF_W + 1;

    logic [HALF_W-1:0] hi_q, lo_q;
    logic [SUM_W-1:0]  lo_sum;
    logic [SUM_W-1:0]  hi_sum;
    logic              lo_carry;
    logic              ovf;

    // Purpose: low-half add and carry-chained high-half increment.
    always_comb begin
        lo_sum   = SUM_W'(lo_q) + SUM_W'(op_i);
        lo_carry = lo_sum[HALF_W];
        hi_sum   = SUM_W'(hi_q) + SUM_W'(lo_carry);
        ovf      = hi_sum[HALF_W];
    end

    // Purpose: register both halves with reset, clear, add and saturate.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (en_i) begin
            if (ovf) begin
                hi_q <= '1;
                lo_q <= '1;
            end else begin
                hi_q <= hi_sum[HALF_W-1:0];
                lo_q <= lo_sum[HALF_W-1:0];
            end
        end
    end

    assign hi_o = hi_q;
    assign lo_o = lo_q;

    // R8: a low half that went down must have passed its carry upward.
    a_r8_carry_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i) |=> ((lo_q >= $past(lo_q)) || (hi_q == $past(hi_q) + 1'b1)));

    // R9: a saturated total stays saturated without a clear.
    a_r9_sat_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && hi_q == '1 && lo_q == '1) |=> (hi_q == '1 && lo_q == '1));

    // R3: nothing moves while neither clear nor enable is set.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !en_i) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/ora_resp_analyzer.sv
// Module: top of the accumulating response analyzer. Computes the operand
// for the selected mode and sums it into a saturating two-half total.
// Assumes HALF_W >= max(TPG_W, ADC_W); inputs change only between edges.
module ora_resp_analyzer
    import ora_pkg::*;
#(
    parameter int TPG_W  = 4,
    parameter int ADC_W  = 4,
    parameter int HALF_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              acc_en,
    input  logic [1:0]        mode,
    input  logic [TPG_W-1:0]  tpg_data,
    input  logic [ADC_W-1:0]  adc_data,
    output logic [HALF_W-1:0] acc_hi,
    output logic [HALF_W-1:0] acc_lo
);
    localparam int OP_W = (TPG_W > ADC_W) ? TPG_W : ADC_W;

    ora_mode_e       mode_e;
    logic [OP_W-1:0] absdiff;
    logic [OP_W-1:0] operand;

    // Purpose: give the raw mode bits their enumerated meaning.
    always_comb mode_e = ora_mode_e'(mode);

    ora_absdiff #(.A_W(TPG_W), .B_W(ADC_W), .OP_W(OP_W)) u_absdiff (
        .a_i   (tpg_data),
        .b_i   (adc_data),
        .mag_o (absdiff)
    );

    ora_operand_mux #(.TPG_W(TPG_W), .ADC_W(ADC_W), .OP_W(OP_W)) u_mux (
        .mode_i    (mode_e),
        .tpg_i     (tpg_data),
        .adc_i     (adc_data),
        .absdiff_i (absdiff),
        .op_o      (operand)
    );

    ora_accum #(.OP_W(OP_W), .HALF_W(HALF_W)) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (start),
        .en_i  (acc_en),
        .op_i  (operand),
        .hi_o  (acc_hi),
        .lo_o  (acc_lo)
    );

    // R2: a start pulse leaves a zero total, enable or not.
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (acc_hi == '0 && acc_lo == '0));

    // R7: the reserved mode contributes nothing.
    a_r7_reserved_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && acc_en && mode == 2'b11) |=> ($stable(acc_hi) && $stable(acc_lo)));

    // R5: matching stimulus and sample leave the total unchanged.
    a_r5_equal_adds_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && acc_en && mode == 2'b01 && OP_W'(tpg_data) == OP_W'(adc_data))
        |=> ($stable(acc_hi) && $stable(acc_lo)));
endmodule

// File: tb/ora_resp_analyzer_tb_top.sv
module ora_resp_analyzer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TPG_W  = 4;
    localparam int ADC_W  = 4;
    localparam int HALF_W = 6;
    localparam int TOT_W  = 2 * HALF_W;
    localparam longint MAXV = (64'd1 << TOT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              acc_en = 1'b0;
    logic [1:0]        mode = 2'b00;
    logic [TPG_W-1:0]  tpg_data = '0;
    logic [ADC_W-1:0]  adc_data = '0;
    logic [HALF_W-1:0] acc_hi, acc_lo;

    int     n_chk = 0;
    int     n_bad = 0;
    longint model = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ora_resp_analyzer #(.TPG_W(TPG_W), .ADC_W(ADC_W), .HALF_W(HALF_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .acc_en(acc_en), .mode(mode),
        .tpg_data(tpg_data), .adc_data(adc_data), .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    task automatic check(input string req, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic longint total();
        return longint'({acc_hi, acc_lo});
    endfunction

    // Operand expected for a mode, computed from the requirements.
    function automatic longint operand(input logic [1:0] m, input int t, input int a);
        case (m)
            2'b00:   return a;
            2'b01:   return (t > a) ? t - a : a - t;
            2'b10:   return t;
            default: return 0;
        endcase
    endfunction

    // One cycle: drive at falling edge, pass a rising edge, sample at next falling edge.
    task automatic step(input string req, input logic st, input logic en,
                        input logic [1:0] m, input int t, input int a);
        start = st; acc_en = en; mode = m;
        tpg_data = TPG_W'(t); adc_data = ADC_W'(a);
        // R10: nothing visible before the edge
        #1 check("R10", total(), model);
        @(posedge clk);
        if (st) model = 0;
        else if (en) begin
            model = model + operand(m, t, a);
            if (model > MAXV) model = MAXV;
        end
        @(negedge clk);
        check(req, total(), model);
    endtask

    task automatic sweep(input string req, input logic [1:0] m);
        step("R2", 1'b1, 1'b1, m, 15, 15);
        for (int t = 0; t < (1 << TPG_W); t++)
            for (int a = 0; a < (1 << ADC_W); a++)
                step(req, 1'b0, 1'b1, m, t, a);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++; n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        check("R1", total(), 0);
        rst_n = 1'b1;
        model = 0;
        step("R2", 1'b1, 1'b0, 2'b00, 0, 0);
        sweep("R4 R8", 2'b00);       // magnitude: total 1920 crosses many carries
        check("R8", total(), 1920);
        sweep("R5 R8", 2'b01);       // difference
        check("R5", total(), 1360);
        sweep("R6 R8", 2'b10);       // self-check
        check("R6", total(), 1920);
        // R3: enable low, all data and modes varied
        for (int k = 0; k < 16; k++)
            step("R3", 1'b0, 1'b0, 2'(k), k, 15 - k);
        // R7: reserved mode enabled
        for (int k = 0; k < 16; k++)
            step("R7", 1'b0, 1'b1, 2'b11, k, 15 - k);
        // R9: drive full-scale samples past the top of the sum
        step("R2", 1'b1, 1'b0, 2'b00, 0, 0);
        for (int k = 0; k < 290; k++)
            step("R9", 1'b0, 1'b1, 2'b00, 0, 15);
        check("R9", total(), MAXV);
        step("R9", 1'b0, 1'b1, 2'b10, 1, 0);
        check("R9", total(), MAXV);
        // R1: reset in the middle of a run
        rst_n = 1'b0; acc_en = 1'b1; start = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1", total(), 0);
        rst_n = 1'b1; model = 0;
        step("R4", 1'b0, 1'b1, 2'b00, 0, 9);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule